// File: doc/BRIEF.md
# Fractional Baud-Rate Prescaler

This block turns the peripheral bus clock into the 16x oversampling enable that a UART receiver and transmitter step on. A plain divisor alone can only reach rates of the form fclk / N. Here the divisor is stretched by a small rational factor (1 + A/M). A is a 4-bit add value and M is a 4-bit multiplier, and both are packed into one 8-bit control word. The output is a single-cycle enable, `tick_o`, whose average period is N × (M + A) / M clock cycles. The individual periods are spread as evenly as whole cycles allow.

The enable comes from a digital differential accumulator. Every clock cycle it adds M, and it fires whenever the running sum reaches N × (M + A). The remainder is kept, so the long-run rate is exact. When the add value is zero the block works as a plain divide-by-N. The divisor and control inputs are captured into shadow registers only at a period boundary, so software can rewrite them at any time without producing a malformed period. Settings that cannot work fall back to the plain divide-by-N and latch an error flag. These are a zero multiplier, or a divisor below 3 while the fraction is active.

Top module: `frac_baud_prescaler`

## Requirements
- R1: The control word carries the add value in bits 3:0 and the multiplier in bits 7:4.
- R2: With add value 0, a nonzero divisor N and a nonzero multiplier, `tick_o` fires exactly every N cycles. The multiplier has no effect in this case.
- R3: With the fraction active (add A > 0, multiplier M > 0, N ≥ 3), any M consecutive tick intervals span exactly N × (M + A) cycles.
- R4: Each single tick interval is either floor or ceil of N × (M + A) / M cycles. In bypass this reduces to N.
- R5: A multiplier of 0 makes the block behave as divide-by-N and sets `frac_err_o`.
- R6: An active fraction with a divisor below 3 (upper byte 0 and lower byte 2 or less) makes the block behave as divide-by-N and sets `frac_err_o`. A divisor of exactly 3 is legal.
- R7: `frac_err_o` stays set until reset, and legal settings that follow do not clear it.
- R8: A divisor of 0 stops all ticks once it has been captured.
- R9: During and right after reset `tick_o` and `frac_err_o` are 0. The captured state starts at divisor 0, add 0 and multiplier 1, so the block stays idle until a nonzero divisor arrives.
- R10: Input changes take effect at the next tick. The interval running when the inputs change keeps its old length.
- R11: `tick_o` is high for exactly one cycle whenever the current period is 2 cycles or longer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| divisor_i | input | 16 | Integer divisor N |
| frac_ctrl_i | input | 8 | Add value in [3:0], multiplier in [7:4] |
| tick_o | output | 1 | 16x baud enable, one cycle per period |
| frac_err_o | output | 1 | Sticky flag for an illegal fractional setting |

## Verification
Two functions can fall in the same cycle: the end of a period (a tick) and the capture of new settings. The capture is allowed only at that boundary. The bench provokes the collision by rewriting the divisor in the very cycle a tick is visible. It then checks that the next interval still has the old length and that the one after it has the new length. A second collision, between the error capture and a tick, is provoked by random settings that include illegal ones. Each is judged by comparing the sticky flag against a bench-side legality model after every setting change.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

  // Smallest divisor the accumulator accepts while the fraction is active
  localparam int MIN_FRAC_DIV = 3;

  typedef enum logic [1:0] {
    PM_IDLE  = 2'd0,
    PM_WHOLE = 2'd1,
    PM_FRAC  = 2'd2
  } pm_mode_e;

endpackage

// File: rtl/frac_rst_sync.sv
module frac_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;

endmodule

// File: rtl/frac_cfg_shadow.sv
module frac_cfg_shadow
  import frac_baud_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [DIV_W-1:0]      div_i,
  input  logic [2*FRAC_W-1:0]   ctrl_i,
  output logic [DIV_W-1:0]      sh_div,
  output logic [FRAC_W-1:0]     sh_add,
  output logic [FRAC_W-1:0]     sh_mul,
  output logic                  chg,
  output logic                  err,
  output pm_mode_e              mode
);

  logic [FRAC_W-1:0] add_raw, mul_raw;
  logic [FRAC_W-1:0] new_add, new_mul;
  logic              illegal, whole;
  logic [DIV_W-1:0]  div_d;
  logic [FRAC_W-1:0] add_d, mul_d;
  logic              err_d;

  // field split and legalisation of the incoming setting
  always_comb begin
    add_raw = ctrl_i[FRAC_W-1:0];
    mul_raw = ctrl_i[2*FRAC_W-1:FRAC_W];
    illegal = (mul_raw == '0) ||
              ((add_raw != '0) && (div_i < DIV_W'(MIN_FRAC_DIV)));
    whole   = illegal || (add_raw == '0);
    new_add = whole ? '0 : add_raw;
    new_mul = whole ? FRAC_W'(1) : mul_raw;
    chg     = (div_i != sh_div) || (new_add != sh_add) || (new_mul != sh_mul);
  end

  // next state with explicit load enable
  always_comb begin
    div_d = sh_div;
    add_d = sh_add;
    mul_d = sh_mul;
    if (load) begin
      div_d = div_i;
      add_d = new_add;
      mul_d = new_mul;
    end
    err_d = err | (load & illegal);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_div <= '0;
      sh_add <= '0;
      sh_mul <= FRAC_W'(1);
      err    <= 1'b0;
    end else begin
      sh_div <= div_d;
      sh_add <= add_d;
      sh_mul <= mul_d;
      err    <= err_d;
    end
  end

  always_comb begin
    if (sh_div == '0)      mode = PM_IDLE;
    else if (sh_add != '0) mode = PM_FRAC;
    else                   mode = PM_WHOLE;
  end

endmodule

// File: rtl/frac_dda.sv
module frac_dda
  import frac_baud_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 4,
  localparam int SUM_W = FRAC_W + 1,
  localparam int LIM_W = DIV_W + SUM_W,
  localparam int ACC_W = LIM_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pm_mode_e          mode,
  input  logic [DIV_W-1:0]  sh_div,
  input  logic [FRAC_W-1:0] sh_add,
  input  logic [FRAC_W-1:0] sh_mul,
  input  logic              chg,
  output logic              hit,
  output logic              tick,
  output logic [ACC_W-1:0]  acc,
  output logic [FRAC_W-1:0] step,
  output logic [LIM_W-1:0]  lim
);

  logic [SUM_W-1:0] ratio_sum;
  logic [ACC_W-1:0] acc_sum;
  logic [ACC_W-1:0] acc_d;

  // threshold N*(M+A) and per-cycle increment M
  always_comb begin
    ratio_sum = SUM_W'(sh_mul) + SUM_W'(sh_add);
    lim       = LIM_W'(sh_div) * LIM_W'(ratio_sum);
    step      = sh_mul;
    acc_sum   = acc + ACC_W'(step);
    hit       = (mode != PM_IDLE) && (acc_sum >= ACC_W'(lim));
  end

  always_comb begin
    if (mode == PM_IDLE) acc_d = '0;
    else if (hit)        acc_d = chg ? '0 : (acc_sum - ACC_W'(lim));
    else                 acc_d = acc_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      tick <= 1'b0;
    end else begin
      acc  <= acc_d;
      tick <= hit;
    end
  end

endmodule

// File: rtl/frac_baud_prescaler.sv
module frac_baud_prescaler
  import frac_baud_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 4,
  localparam int LIM_W = DIV_W + FRAC_W + 1,
  localparam int ACC_W = LIM_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DIV_W-1:0]    divisor_i,
  input  logic [2*FRAC_W-1:0] frac_ctrl_i,
  output logic                tick_o,
  output logic                frac_err_o
);

  logic              srst_n;
  logic              load;
  logic              hit;
  logic              chg;
  pm_mode_e          mode;
  logic [DIV_W-1:0]  sh_div;
  logic [FRAC_W-1:0] sh_add, sh_mul;
  logic [ACC_W-1:0]  acc;
  logic [FRAC_W-1:0] step;
  logic [LIM_W-1:0]  lim;

  frac_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  // capture only at a period boundary, or continuously while idle
  assign load = hit || (mode == PM_IDLE);

  frac_cfg_shadow #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_cfg (
    .clk    (clk),
    .rst_n  (srst_n),
    .load   (load),
    .div_i  (divisor_i),
    .ctrl_i (frac_ctrl_i),
    .sh_div (sh_div),
    .sh_add (sh_add),
    .sh_mul (sh_mul),
    .chg    (chg),
    .err    (frac_err_o),
    .mode   (mode)
  );

  frac_dda #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_dda (
    .clk    (clk),
    .rst_n  (srst_n),
    .mode   (mode),
    .sh_div (sh_div),
    .sh_add (sh_add),
    .sh_mul (sh_mul),
    .chg    (chg),
    .hit    (hit),
    .tick   (tick_o),
    .acc    (acc),
    .step   (step),
    .lim    (lim)
  );

endmodule

// File: rtl/frac_baud_chk.sv
module frac_baud_chk #(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 4,
  localparam int LIM_W = DIV_W + FRAC_W + 1,
  localparam int ACC_W = LIM_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              err,
  input logic [DIV_W-1:0]  sh_div,
  input logic [FRAC_W-1:0] sh_add,
  input logic [FRAC_W-1:0] sh_mul,
  input logic [ACC_W-1:0]  acc,
  input logic [FRAC_W-1:0] step,
  input logic [LIM_W-1:0]  lim
);

  logic [LIM_W:0] two_step;
  assign two_step = (LIM_W+1)'(step) << 1;

  // R11: a period of two cycles or more never shows back-to-back ticks
  p_tick_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ({1'b0, lim} >= two_step)) |=> !tick);

  // R8: nothing fires while the captured divisor is zero
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_div == '0) |=> !tick);

  // R7: error flag only ever stays set
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R4: the remainder stays below the threshold, so no period is skipped
  p_acc_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_div != '0) |-> (acc < ACC_W'(lim)));

  // R5 / R6: the captured state never holds an illegal fraction
  p_frac_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_add != '0) |-> ((sh_div >= DIV_W'(3)) && (sh_mul != '0)));

  p_mul_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sh_mul != '0);

  // R9: quiet outputs while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r9: assert (!tick && !err);
    end
  end

endmodule

bind frac_baud_prescaler frac_baud_chk #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_chk (
  .clk    (clk),
  .rst_n  (srst_n),
  .tick   (tick_o),
  .err    (frac_err_o),
  .sh_div (sh_div),
  .sh_add (sh_add),
  .sh_mul (sh_mul),
  .acc    (acc),
  .step   (step),
  .lim    (lim)
);

// File: tb/tb_frac_baud_prescaler.sv
module tb_frac_baud_prescaler;

  logic        clk;
  logic        rst_n;
  logic [15:0] divisor_i;
  logic [7:0]  frac_ctrl_i;
  logic        tick_o;
  logic        frac_err_o;

  int     n_chk;
  int     n_bad;
  longint cyc;
  bit     exp_err;

  frac_baud_prescaler dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .divisor_i   (divisor_i),
    .frac_ctrl_i (frac_ctrl_i),
    .tick_o      (tick_o),
    .frac_err_o  (frac_err_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit cfg_bad(input int d, input int a, input int m);
    return (m == 0) || ((a != 0) && (d < 3));
  endfunction

  task automatic wait_tick(output longint t);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick_o && n < 20000);
    if (!tick_o) check(1'b0, "watchdog", n, 0);
    t = cyc;
  endtask

  task automatic do_reset();
    @(negedge clk);
    divisor_i   = '0;
    frac_ctrl_i = 8'h10;
    rst_n       = 1'b0;
    exp_err     = 1'b0;
    repeat (4) @(negedge clk);
    check(!tick_o && !frac_err_o, "R9", {tick_o, frac_err_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!tick_o && !frac_err_o, "R9", {tick_o, frac_err_o}, 0);
  endtask

  // apply a setting, let it settle, then measure 4*M intervals
  task automatic run_cfg(input int d, input int a, input int m, input string req);
    int     ea, em;
    longint L, lo, hi, t0, tp, tc;
    bit     bad;
    bad = cfg_bad(d, a, m);
    ea  = (bad || a == 0) ? 0 : a;
    em  = (bad || a == 0) ? 1 : m;
    L   = longint'(d) * (em + ea);
    lo  = L / em;
    hi  = (L + em - 1) / em;
    @(negedge clk);
    divisor_i   = 16'(d);
    frac_ctrl_i = {4'(m), 4'(a)};
    exp_err     = exp_err | bad;
    wait_tick(tp);
    wait_tick(tp);
    wait_tick(t0);
    tp = t0;
    for (int k = 0; k < 4 * em; k++) begin
      wait_tick(tc);
      check((tc - tp >= lo) && (tc - tp <= hi), "R4", tc - tp, lo);
      tp = tc;
    end
    check(tp - t0 == 4 * L, req, tp - t0, 4 * L);
    check(frac_err_o == exp_err, bad ? req : "R7", frac_err_o, exp_err);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    longint t1, t2, tx;
    int     seen;
    void'($urandom(32'd1234));
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    divisor_i   = '0;
    frac_ctrl_i = 8'h10;
    exp_err     = 1'b0;

    // R9 / R8: idle after reset with a zero divisor
    do_reset();
    seen = 0;
    repeat (60) begin
      @(negedge clk);
      if (tick_o) seen++;
    end
    check(seen == 0, "R8", seen, 0);

    // R2: whole-number division, multiplier ignored
    run_cfg(5, 0, 1, "R2");
    run_cfg(7, 0, 9, "R2");
    run_cfg(1, 0, 4, "R2");

    // R1 / R3: field order and fractional rate
    run_cfg(4, 1, 3, "R1");
    run_cfg(4, 3, 1, "R1");
    run_cfg(10, 5, 7, "R3");
    run_cfg(3, 2, 5, "R6");
    run_cfg(6, 15, 15, "R3");

    // R10 / R11: rewrite the divisor in the cycle a tick is visible
    run_cfg(10, 0, 1, "R2");
    wait_tick(tx);
    divisor_i = 16'd3;
    @(negedge clk);
    check(!tick_o, "R11", tick_o, 0);
    wait_tick(t1);
    check(t1 - tx == 10, "R10", t1 - tx, 10);
    wait_tick(t2);
    check(t2 - t1 == 3, "R10", t2 - t1, 3);

    // R8: zero divisor stops ticks once captured
    divisor_i = '0;
    wait_tick(tx);
    seen = 0;
    repeat (300) begin
      @(negedge clk);
      if (tick_o) seen++;
    end
    check(seen == 0, "R8", seen, 0);

    // random settings, illegal ones included
    for (int i = 0; i < 20; i++) begin
      int d, a, m;
      d = 1 + int'($urandom % 12);
      a = int'($urandom % 16);
      m = int'($urandom % 16);
      run_cfg(d, a, m, cfg_bad(d, a, m) ? "R5" : (a == 0 ? "R2" : "R3"));
    end

    // R5 / R6 / R7: illegal settings after a clean reset
    do_reset();
    check(frac_err_o == 1'b0, "R7", frac_err_o, 0);
    run_cfg(2, 1, 4, "R6");
    run_cfg(8, 0, 0, "R5");
    run_cfg(6, 2, 3, "R7");
    check(frac_err_o == 1'b1, "R7", frac_err_o, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule